// File: doc/BRIEF.md
# Averaging Counter Phase Detector

This block measures how far the local oscillator lags the reference carrier. It counts cycles of a fast, free-running clock that has no relation to either signal. A measurement starts on a reference-carrier edge and stops on the next local-oscillator edge. The raw cycle count is shifted by a fixed centre, which gives a signed error that is zero when the two edges are half a nominal carrier period apart.

A measurement is armed only after the carrier has been undisturbed for several consecutive ticks. This keeps intersymbol disturbance out of the result. If the carrier qualifier drops while a measurement is open, that measurement is thrown away. Accepted samples are summed in a wide accumulator. After a power-of-two number of samples (2048 by default), the sum is arithmetically shifted down to a mean. The mean is clamped to a fixed symmetric limit so that it never wraps, and it is presented with a one-cycle valid pulse to a downstream proportional-integral loop filter.

All inputs are single-cycle strobes or levels that are already synchronous to the counting clock.

Top module: `avg_phase_detector`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `phaseValid` is 0 and `phaseOut` is 0.
- R2: A measurement starts only on a `refEdge` cycle with `carrierOk` high that was preceded by at least MIN_CLEAN (default 3) `refEdge` pulses. Each of those earlier pulses must have arrived with `carrierOk` high, and `carrierOk` must have stayed high since the first of them.
- R3: The raw count of a measurement is the number of clock cycles from its starting `refEdge` cycle to the first later `locEdge` cycle. The sample is this raw count minus CENTRE (default 22).
- R4: If `carrierOk` is low on any cycle of an open measurement, the measurement is discarded and does not count toward the block. The clean-tick run also restarts from zero.
- R5: If no `locEdge` arrives within 2*CENTRE cycles of the starting edge, the measurement ends with a raw count of 2*CENTRE. The sample is then +CENTRE.
- R6: After every 2^AVG_LOG2 accepted samples, `phaseValid` is high for exactly one cycle. This is the cycle after the edge that ends the last sample. `phaseOut` then equals floor(sum of the samples / 2^AVG_LOG2), which rounds toward minus infinity.
- R7: `phaseOut` is clamped to the range -PHASE_LIM to +PHASE_LIM and never wraps.
- R8: A `refEdge` while a measurement is open has no effect on it. A `locEdge` while no measurement is open has no effect.
- R9: `phaseOut` holds its value on every cycle on which `phaseValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast free-running counting clock |
| rstN | input | 1 | Active-low synchronous reset |
| refEdge | input | 1 | One-cycle pulse on each reference-carrier edge |
| locEdge | input | 1 | One-cycle pulse on each local-oscillator edge |
| carrierOk | input | 1 | High while the carrier is undisturbed |
| phaseOut | output | OUT_W | Signed averaged phase error, two's complement |
| phaseValid | output | 1 | One-cycle strobe when `phaseOut` is updated |

## Verification
The bench drives a carrier that drops for one cycle in the middle of an open measurement. A design that kept that measurement, or kept its clean-tick run, would produce its block early and with the wrong mean. Local edges that never come exercise the interval limit, and means beyond the limit on both sides exercise the clamp. A counter without a limit or a clamp would wrap to the opposite sign. Samples that alternate -1 and 0 check the rounding: a design that truncates toward zero would report 0 instead of -1. Stray reference edges during a measurement and stray local edges while idle must leave the mean unchanged; a design that restarted on them would report a different value.

// File: rtl/phdet_pkg.sv
package phdet_pkg;
  typedef struct packed {
    logic startCnt;
    logic takeSample;
  } pdStrobe_t;

  typedef enum logic {ST_IDLE, ST_MEAS} measState_t;
endpackage

// File: rtl/pd_ctrl.sv
module pd_ctrl
  import phdet_pkg::*;
#(
  parameter int MIN_CLEAN = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      refEdge,
  input  logic      locEdge,
  input  logic      carrierOk,
  input  logic      cntAtLimit,
  output pdStrobe_t strobes
);
  localparam int RUN_W = $clog2(MIN_CLEAN + 1);

  measState_t state, nextState;
  logic [RUN_W-1:0] cleanRun;
  logic runFull;

  assign runFull = (cleanRun == RUN_W'(MIN_CLEAN));

  // run of consecutive clean reference ticks, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cleanRun <= '0;
    end else if (!carrierOk) begin
      cleanRun <= '0;
    end else if (refEdge && !runFull) begin
      cleanRun <= cleanRun + 1'b1;
    end
  end

  always_comb begin
    strobes   = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (refEdge && carrierOk && runFull) begin
          strobes.startCnt = 1'b1;
          nextState        = ST_MEAS;
        end
      end
      ST_MEAS: begin
        if (!carrierOk) begin
          nextState = ST_IDLE;
        end else if (locEdge || cntAtLimit) begin
          strobes.takeSample = 1'b1;
          nextState          = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R4
  abort_on_dirty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MEAS && !carrierOk) |=> (state == ST_IDLE));

  // R2
  start_after_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startCnt |-> $past(carrierOk));
endmodule

// File: rtl/pd_datapath.sv
module pd_datapath
  import phdet_pkg::*;
#(
  parameter int CENTRE    = 22,
  parameter int AVG_LOG2  = 11,
  parameter int OUT_W     = 16,
  parameter int PHASE_LIM = 32767
) (
  input  logic             clk,
  input  logic             rstN,
  input  pdStrobe_t        strobes,
  output logic             cntAtLimit,
  output logic [OUT_W-1:0] phaseOut,
  output logic             phaseValid
);
  localparam int LIMIT  = 2 * CENTRE;
  localparam int CNT_W  = $clog2(LIMIT + 1);
  localparam int SAMP_W = CNT_W + 1;
  localparam int ACC_W  = SAMP_W + AVG_LOG2;
  localparam int CMP_W  = ((ACC_W > OUT_W) ? ACC_W : OUT_W) + 1;

  logic [CNT_W-1:0]         cnt;
  logic signed [SAMP_W-1:0] sample;
  logic signed [ACC_W-1:0]  acc, accSum, avg;
  logic [AVG_LOG2-1:0]      sampCount;
  logic                     lastSample;
  logic signed [CMP_W-1:0]  avgWide, limPos, limNeg, clamped;

  // interval counter: restarts at 1 on a start, saturates at LIMIT
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobes.startCnt) begin
      cnt <= CNT_W'(1);
    end else if (!cntAtLimit) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign cntAtLimit = (cnt == CNT_W'(LIMIT));
  assign sample     = $signed({1'b0, cnt}) - $signed(SAMP_W'(CENTRE));
  assign accSum     = acc + {{AVG_LOG2{sample[SAMP_W-1]}}, sample};
  assign avg        = accSum >>> AVG_LOG2;
  assign lastSample = &sampCount;

  always_comb begin
    avgWide = {{(CMP_W - ACC_W){avg[ACC_W-1]}}, avg};
    limPos  = CMP_W'(PHASE_LIM);
    limNeg  = -limPos;
    if (avgWide > limPos)      clamped = limPos;
    else if (avgWide < limNeg) clamped = limNeg;
    else                       clamped = avgWide;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc        <= '0;
      sampCount  <= '0;
      phaseOut   <= '0;
      phaseValid <= 1'b0;
    end else begin
      phaseValid <= 1'b0;
      if (strobes.takeSample) begin
        sampCount <= sampCount + 1'b1;
        if (lastSample) begin
          acc        <= '0;
          phaseOut   <= OUT_W'(clamped);
          phaseValid <= 1'b1;
        end else begin
          acc <= accSum;
        end
      end
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(LIMIT));

  // R7
  out_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($signed(phaseOut) <= PHASE_LIM) && ($signed(phaseOut) >= -PHASE_LIM));

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseValid |=> !phaseValid);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !phaseValid |-> $stable(phaseOut));
endmodule

// File: rtl/avg_phase_detector.sv
module avg_phase_detector
  import phdet_pkg::*;
#(
  parameter int CENTRE    = 22,
  parameter int AVG_LOG2  = 11,
  parameter int MIN_CLEAN = 3,
  parameter int OUT_W     = 16,
  parameter int PHASE_LIM = 32767
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refEdge,
  input  logic             locEdge,
  input  logic             carrierOk,
  output logic [OUT_W-1:0] phaseOut,
  output logic             phaseValid
);
  pdStrobe_t strobes;
  logic      cntAtLimit;

  pd_ctrl #(.MIN_CLEAN(MIN_CLEAN)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .refEdge   (refEdge),
    .locEdge   (locEdge),
    .carrierOk (carrierOk),
    .cntAtLimit(cntAtLimit),
    .strobes   (strobes)
  );

  pd_datapath #(
    .CENTRE   (CENTRE),
    .AVG_LOG2 (AVG_LOG2),
    .OUT_W    (OUT_W),
    .PHASE_LIM(PHASE_LIM)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cntAtLimit(cntAtLimit),
    .phaseOut  (phaseOut),
    .phaseValid(phaseValid)
  );
endmodule

// File: tb/test_avg_phase_detector.sv
module test_avg_phase_detector;
  localparam int CENTRE = 22, AVG_LOG2 = 3, MIN_CLEAN = 3, OUT_W = 16, LIM = 15;
  localparam int NSAMP = 1 << AVG_LOG2;
  localparam int PERIOD = 45;

  logic clk = 1'b0, rstN = 1'b0, refEdge = 1'b0, locEdge = 1'b0, carrierOk = 1'b0;
  logic [OUT_W-1:0] phaseOut;
  logic phaseValid;

  int checks = 0, fails = 0, validSeen = 0;
  string curReq = "R1";

  // behavioural reference state
  int run = 0, cnt = 0, expOut = 0;
  bit meas = 0, expValid = 0;
  int q[$];

  always #4ns clk = ~clk;

  avg_phase_detector #(.CENTRE(CENTRE), .AVG_LOG2(AVG_LOG2), .MIN_CLEAN(MIN_CLEAN),
                       .OUT_W(OUT_W), .PHASE_LIM(LIM)) i_avg_phase_detector (
    .clk(clk), .rstN(rstN), .refEdge(refEdge), .locEdge(locEdge),
    .carrierOk(carrierOk), .phaseOut(phaseOut), .phaseValid(phaseValid));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pushSample(input int s);
    int sum = 0;
    q.push_back(s);
    if (q.size() == NSAMP) begin
      foreach (q[k]) sum += q[k];
      sum = sum >>> AVG_LOG2;
      if (sum > LIM) sum = LIM;
      if (sum < -LIM) sum = -LIM;
      expOut = sum;
      expValid = 1;
      q.delete();
    end
  endtask

  task automatic modelStep(input bit r, input bit l, input bit ok);
    bit startNow;
    expValid = 0;
    startNow = !meas && r && ok && (run == MIN_CLEAN);
    if (meas) begin
      if (!ok) meas = 0;
      else if (l || cnt == 2 * CENTRE) begin
        meas = 0;
        pushSample(cnt - CENTRE);
      end else cnt++;
    end else if (startNow) begin
      meas = 1;
      cnt = 1;
    end
    if (!ok) run = 0;
    else if (r && run < MIN_CLEAN) run++;
  endtask

  task automatic step(input bit r, input bit l, input bit ok);
    @(negedge clk);
    refEdge = r; locEdge = l; carrierOk = ok;
    @(posedge clk);
    #1;
    modelStep(r, l, ok);
    if (phaseValid) validSeen++;
    check({curReq, " valid"}, int'(phaseValid), int'(expValid));
    check({curReq, " phase"}, int'($signed(phaseOut)), expOut);
  endtask

  // one carrier period: ref at cycle 0, loc at cycle lag, optional extras
  task automatic tick(input int lag, input int dropAt, input bit extraRef, input bit strayLoc);
    for (int c = 0; c < PERIOD; c++) begin
      step((c == 0) || (extraRef && c == 3),
           (c == lag) || (strayLoc && c == PERIOD - 2),
           (c != dropAt));
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R1 during reset
    check("R1 valid in reset", int'(phaseValid), 0);
    check("R1 phase in reset", int'($signed(phaseOut)), 0);
    @(negedge clk);
    rstN = 1'b1;
    step(0, 0, 0);
    check("R1 valid after reset", int'(phaseValid), 0);

    // R2, R3: three warm-up ticks, then samples of 30-22 = 8
    curReq = "R3";
    for (int i = 0; i < 3 + NSAMP - 1; i++) tick(30, -1, 0, 0);
    check("R2 no block before warm-up plus 8 samples", validSeen, 0);
    tick(30, -1, 0, 0);
    check("R6 one block after 8 samples", validSeen, 1);
    check("R3 mean of lag 30", int'($signed(phaseOut)), 8);

    // R4: drop during an open measurement, restart the run
    curReq = "R4";
    tick(30, 10, 0, 0);
    for (int i = 0; i < 3 + NSAMP - 1; i++) tick(10, -1, 0, 0);
    check("R4 discarded sample not counted", validSeen, 1);
    tick(10, -1, 0, 0);
    check("R4 block after restart", validSeen, 2);
    check("R4 mean of lag 10", int'($signed(phaseOut)), -12);

    // R7 negative clamp: lag 5 gives -17
    curReq = "R7";
    for (int i = 0; i < NSAMP; i++) tick(5, -1, 0, 0);
    check("R7 negative clamp", int'($signed(phaseOut)), -LIM);

    // R5 no local edge: sample +22, clamped to +15
    curReq = "R5";
    for (int i = 0; i < NSAMP; i++) tick(999, -1, 0, 0);
    check("R5 interval limit then R7 positive clamp", int'($signed(phaseOut)), LIM);

    // R6 floor rounding: samples -1,0 alternating -> -0.5 -> -1
    curReq = "R6";
    for (int i = 0; i < NSAMP; i++) tick(21 + (i % 2), -1, 0, 0);
    check("R6 floor of negative mean", int'($signed(phaseOut)), -1);

    // R8 stray edges ignored
    curReq = "R8";
    for (int i = 0; i < NSAMP; i++) tick(30, -1, 1, 1);
    check("R8 stray edges leave mean", int'($signed(phaseOut)), 8);
    check("R8 block count", validSeen, 6);

    // R9 holds while a partial block builds
    curReq = "R9";
    for (int i = 0; i < NSAMP - 2; i++) tick(5, -1, 0, 0);
    check("R9 output held", int'($signed(phaseOut)), 8);
    check("R9 no extra valid", validSeen, 6);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule